// File: doc/BRIEF.md
# Tagged DMA Command Queue Controller

This block sits between two issuers of DMA transfer commands and a single transfer engine. One issuer is the local compute core, the other is a host reaching the block through a memory-mapped port. Each issuer owns its own command queue: sixteen entries for the local core and eight for the host. A command names a direction, a 5-bit tag, a byte count, a local address and a main-memory address. It may also carry an ordering qualifier, either fence or barrier. Byte counts are checked on entry. A command with an illegal count is flagged and dropped.

Each cycle the block picks at most one command and hands it to the transfer engine. The local queue always wins when it has an eligible command. Within a queue the oldest eligible entry goes first. A command held back by its ordering qualifier does not stall entries with other tags behind it. The transfer engine is a stub with a fixed number of slots. Each slot completes after a programmable base latency plus one cycle per 16-byte beat, then reports the finished tag.

A 32-bit status vector shows, per tag, whether that tag group has nothing queued and nothing in flight. A 32-bit mask selects tags, and one output reports whether every selected group is idle.

Top module: `dma_tagq_ctrl`

## Requirements
- R1: The local queue holds 16 commands and the host queue holds 8. A source's ready output is low exactly when its queue is full. A command is taken on a clock edge where valid and ready are both high and its size is legal.
- R2: When both queues hold an eligible command, the local one is issued. A host command is issued only in a cycle where no local command is eligible.
- R3: A size is legal only if it is 1, 2, 4 or 8, or a multiple of 16 from 16 to 16384. The error output equals valid AND illegal size, independent of ready. An illegal command is never queued, so it leaves the tag status unchanged and is never issued.
- R4: The put flag is 1 for a put (local storage to main memory) and 0 for a get (main memory to local storage). When a command is issued, its direction, source, tag, size and both addresses appear unchanged on the xfer outputs. Source is 0 for local and 1 for host.
- R5: A fenced command is not issued until every earlier command in its queue with the same tag has completed. Later commands with the same tag and no qualifier may be issued before it.
- R6: A barrier command waits as a fenced one does. In addition, no later command with the same tag in its queue is issued before the barrier itself.
- R7: A command held by R5 or R6 does not delay commands with other tags queued behind it.
- R8: Bit n of tag_status is 1 when no command with tag n is queued in either queue or in flight. tag_idle_all is 1 when every tag selected by a 1 in tag_mask has its status bit set.
- R9: With no completion contention, cpl_valid rises exactly lat_base plus ceil(size/16) cycles after the issue cycle, with the command's source and tag. The engine holds up to 4 transfers at once.
- R10: Among eligible entries of one queue, the oldest is issued first, so commands of one tag without qualifiers leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lc_valid | input | 1 | Local-core command valid |
| lc_ready | output | 1 | Local queue has room |
| lc_err | output | 1 | Local command has an illegal size |
| lc_put | input | 1 | 1 = put, 0 = get |
| lc_fence | input | 1 | Fence qualifier |
| lc_barrier | input | 1 | Barrier qualifier |
| lc_tag | input | 5 | Tag group |
| lc_size | input | 15 | Byte count |
| lc_laddr | input | 18 | Local storage address |
| lc_eaddr | input | 32 | Main-memory address |
| hs_valid | input | 1 | Host command valid |
| hs_ready | output | 1 | Host queue has room |
| hs_err | output | 1 | Host command has an illegal size |
| hs_put | input | 1 | 1 = put, 0 = get |
| hs_fence | input | 1 | Fence qualifier |
| hs_barrier | input | 1 | Barrier qualifier |
| hs_tag | input | 5 | Tag group |
| hs_size | input | 15 | Byte count |
| hs_laddr | input | 18 | Local storage address |
| hs_eaddr | input | 32 | Main-memory address |
| lat_base | input | 8 | Base completion latency in cycles |
| xfer_start | output | 1 | A command is issued this cycle |
| xfer_src | output | 1 | Source of issued command |
| xfer_put | output | 1 | Direction of issued command |
| xfer_tag | output | 5 | Tag of issued command |
| xfer_size | output | 15 | Size of issued command |
| xfer_laddr | output | 18 | Local address of issued command |
| xfer_eaddr | output | 32 | Main-memory address of issued command |
| cpl_valid | output | 1 | A transfer completes this cycle |
| cpl_src | output | 1 | Source of completed transfer |
| cpl_tag | output | 5 | Tag of completed transfer |
| tag_mask | input | 32 | Tag selection for the idle query |
| tag_status | output | 32 | Per-tag idle vector |
| tag_idle_all | output | 1 | All selected tag groups are idle |

## Verification
Two functions can fall in the same cycle. The first pair is a queue removing an entry from the middle for issue while it also appends a newly accepted command. The second pair is the in-flight count of one tag going up on an issue and down on a completion in the same cycle. The bench provokes both by pushing streams of short same-tag commands while long transfers drain and short ones complete back to back. The issue order of every command, identified by its address, is then compared against the fence, barrier, priority and age rules. The tag status must return to all ones once traffic stops.

// File: rtl/dma_tq_pkg.sv
package dma_tq_pkg;
  parameter int TAG_W      = 5;
  parameter int NTAG       = 1 << TAG_W;
  parameter int SIZE_W     = 15;
  parameter int MAX_BYTES  = 16384;
  parameter int BEAT_SHIFT = 4;
  parameter int LADDR_W    = 18;
  parameter int EADDR_W    = 32;
  parameter int BEATS_W    = SIZE_W - BEAT_SHIFT + 1;

  typedef struct packed {
    logic               put;
    logic               fence;
    logic               barrier;
    logic [TAG_W-1:0]   tag;
    logic [SIZE_W-1:0]  size;
    logic [LADDR_W-1:0] laddr;
    logic [EADDR_W-1:0] eaddr;
  } dma_cmd_t;

  // small power-of-two counts, or whole 16-byte blocks up to the limit
  function automatic logic size_legal(input logic [SIZE_W-1:0] s);
    logic small_ok;
    logic block_ok;
    small_ok = (s == SIZE_W'(1)) || (s == SIZE_W'(2)) ||
               (s == SIZE_W'(4)) || (s == SIZE_W'(8));
    block_ok = (s[BEAT_SHIFT-1:0] == '0) && (s != '0) &&
               (s <= SIZE_W'(MAX_BYTES));
    return small_ok || block_ok;
  endfunction

  // number of 16-byte beats, rounded up
  function automatic logic [BEATS_W-1:0] xfer_beats(input logic [SIZE_W-1:0] s);
    logic [SIZE_W:0] t;
    t = {1'b0, s} + (SIZE_W+1)'((1 << BEAT_SHIFT) - 1);
    return t[SIZE_W:BEAT_SHIFT];
  endfunction
endpackage

// File: rtl/dma_tq_queue.sv
module dma_tq_queue
  import dma_tq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  dma_cmd_t         push_cmd_i,
  input  logic             pop_i,
  input  logic [NTAG-1:0]  infl_busy_i,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o,
  output logic             elig_o,
  output dma_cmd_t         sel_cmd_o,
  output logic [NTAG-1:0]  tags_o
);
  dma_cmd_t         ent_q [DEPTH];
  dma_cmd_t         nxt   [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] vld, ahead_same, ahead_bar, elig_vec;
  logic [IDX_W-1:0] sel_idx, wr_idx;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic same_l, bar_l;
    assign vld[gi] = CNT_W'(gi) < cnt_q;
    always_comb begin
      same_l = 1'b0;
      bar_l  = 1'b0;
      for (int j = 0; j < gi; j++) begin
        if (vld[j] && ent_q[j].tag == ent_q[gi].tag) begin
          same_l = 1'b1;
          if (ent_q[j].barrier) bar_l = 1'b1;
        end
      end
    end
    assign ahead_same[gi] = same_l;
    assign ahead_bar[gi]  = bar_l;
    // ordered commands need no older same-tag work queued or in flight
    assign elig_vec[gi] = vld[gi] && !ahead_bar[gi] &&
                          (!(ent_q[gi].fence || ent_q[gi].barrier) ||
                           (!ahead_same[gi] && !infl_busy_i[ent_q[gi].tag]));
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && elig_vec[i]) begin
        sel_idx = IDX_W'(i);
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    tags_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i]) tags_o[ent_q[i].tag] = 1'b1;
  end

  assign wr_idx = IDX_W'(cnt_q - CNT_W'(pop_i));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = ent_q[i];
    if (pop_i)
      for (int i = 0; i < DEPTH - 1; i++)
        if (IDX_W'(i) >= sel_idx) nxt[i] = ent_q[i+1];
    if (push_i) nxt[wr_idx] = push_cmd_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    for (int i = 0; i < DEPTH; i++) ent_q[i] <= nxt[i];
  end

  assign full_o    = cnt_q == CNT_W'(DEPTH);
  assign count_o   = cnt_q;
  assign elig_o    = |elig_vec;
  assign sel_cmd_o = ent_q[sel_idx];
endmodule

// File: rtl/dma_tq_engine.sv
module dma_tq_engine
  import dma_tq_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int LAT_W = 8,
  localparam int SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int TIMER_W = ((LAT_W > BEATS_W) ? LAT_W : BEATS_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              go_i,
  input  logic              go_src_i,
  input  logic [TAG_W-1:0]  go_tag_i,
  input  logic [SIZE_W-1:0] go_size_i,
  output logic              free_o,
  output logic              cpl_o,
  output logic              cpl_src_o,
  output logic [TAG_W-1:0]  cpl_tag_o
);
  logic [NSLOT-1:0]   busy_q;
  logic [TIMER_W-1:0] tmr_q [NSLOT];
  logic [TAG_W-1:0]   tag_q [NSLOT];
  logic               src_q [NSLOT];
  logic [SLOT_W-1:0]  alloc_idx, ret_idx;
  logic [TIMER_W-1:0] load_val;

  always_comb begin
    logic fa, fr;
    fa = 1'b0; fr = 1'b0;
    alloc_idx = '0; ret_idx = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (!fa && !busy_q[s]) begin alloc_idx = SLOT_W'(s); fa = 1'b1; end
      if (!fr && busy_q[s] && tmr_q[s] == '0) begin ret_idx = SLOT_W'(s); fr = 1'b1; end
    end
    free_o = fa;
    cpl_o  = fr;
  end

  assign cpl_src_o = src_q[ret_idx];
  assign cpl_tag_o = tag_q[ret_idx];
  assign load_val  = TIMER_W'(lat_i) + TIMER_W'(xfer_beats(go_size_i)) - TIMER_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        tmr_q[s] <= '0; tag_q[s] <= '0; src_q[s] <= 1'b0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (busy_q[s]) begin
          if (cpl_o && ret_idx == SLOT_W'(s)) busy_q[s] <= 1'b0;
          else if (tmr_q[s] != '0)            tmr_q[s] <= tmr_q[s] - TIMER_W'(1);
        end else if (go_i && alloc_idx == SLOT_W'(s)) begin
          busy_q[s] <= 1'b1;
          tmr_q[s]  <= load_val;
          tag_q[s]  <= go_tag_i;
          src_q[s]  <= go_src_i;
        end
      end
    end
  end
endmodule

// File: rtl/dma_tagq_ctrl.sv
module dma_tagq_ctrl
  import dma_tq_pkg::*;
#(
  parameter int LQ_DEPTH = 16,
  parameter int HQ_DEPTH = 8,
  parameter int NSLOT    = 4,
  parameter int LAT_W    = 8,
  localparam int LQ_CW = $clog2(LQ_DEPTH + 1),
  localparam int HQ_CW = $clog2(HQ_DEPTH + 1),
  localparam int IFL_W = $clog2(NSLOT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lc_valid,
  output logic               lc_ready,
  output logic               lc_err,
  input  logic               lc_put,
  input  logic               lc_fence,
  input  logic               lc_barrier,
  input  logic [TAG_W-1:0]   lc_tag,
  input  logic [SIZE_W-1:0]  lc_size,
  input  logic [LADDR_W-1:0] lc_laddr,
  input  logic [EADDR_W-1:0] lc_eaddr,
  input  logic               hs_valid,
  output logic               hs_ready,
  output logic               hs_err,
  input  logic               hs_put,
  input  logic               hs_fence,
  input  logic               hs_barrier,
  input  logic [TAG_W-1:0]   hs_tag,
  input  logic [SIZE_W-1:0]  hs_size,
  input  logic [LADDR_W-1:0] hs_laddr,
  input  logic [EADDR_W-1:0] hs_eaddr,
  input  logic [LAT_W-1:0]   lat_base,
  output logic               xfer_start,
  output logic               xfer_src,
  output logic               xfer_put,
  output logic [TAG_W-1:0]   xfer_tag,
  output logic [SIZE_W-1:0]  xfer_size,
  output logic [LADDR_W-1:0] xfer_laddr,
  output logic [EADDR_W-1:0] xfer_eaddr,
  output logic               cpl_valid,
  output logic               cpl_src,
  output logic [TAG_W-1:0]   cpl_tag,
  input  logic [NTAG-1:0]    tag_mask,
  output logic [NTAG-1:0]    tag_status,
  output logic               tag_idle_all
);
  dma_cmd_t          lc_cmd, hs_cmd, lq_sel, hq_sel, iss_cmd;
  logic              lq_full, hq_full, lq_elig, hq_elig, lq_push, hq_push;
  logic              lq_pop, hq_pop, eng_free, iss_go, iss_src;
  logic [LQ_CW-1:0]  lq_count;
  logic [HQ_CW-1:0]  hq_count;
  logic [NTAG-1:0]   lq_tags, hq_tags, lq_busy, hq_busy;
  logic              iss_order, iss_tag_busy;

  assign lc_cmd = '{put: lc_put, fence: lc_fence, barrier: lc_barrier, tag: lc_tag,
                    size: lc_size, laddr: lc_laddr, eaddr: lc_eaddr};
  assign hs_cmd = '{put: hs_put, fence: hs_fence, barrier: hs_barrier, tag: hs_tag,
                    size: hs_size, laddr: hs_laddr, eaddr: hs_eaddr};

  assign lc_err   = lc_valid & ~size_legal(lc_size);
  assign hs_err   = hs_valid & ~size_legal(hs_size);
  assign lc_ready = ~lq_full;
  assign hs_ready = ~hq_full;
  assign lq_push  = lc_valid & ~lc_err & ~lq_full;
  assign hq_push  = hs_valid & ~hs_err & ~hq_full;

  dma_tq_queue #(.DEPTH(LQ_DEPTH)) u_lq (
    .clk(clk), .rst_n(rst_n), .push_i(lq_push), .push_cmd_i(lc_cmd), .pop_i(lq_pop),
    .infl_busy_i(lq_busy), .full_o(lq_full), .count_o(lq_count), .elig_o(lq_elig),
    .sel_cmd_o(lq_sel), .tags_o(lq_tags));

  dma_tq_queue #(.DEPTH(HQ_DEPTH)) u_hq (
    .clk(clk), .rst_n(rst_n), .push_i(hq_push), .push_cmd_i(hs_cmd), .pop_i(hq_pop),
    .infl_busy_i(hq_busy), .full_o(hq_full), .count_o(hq_count), .elig_o(hq_elig),
    .sel_cmd_o(hq_sel), .tags_o(hq_tags));

  // fixed priority: the local queue wins whenever it has an eligible entry
  assign lq_pop  = eng_free & lq_elig;
  assign hq_pop  = eng_free & ~lq_elig & hq_elig;
  assign iss_go  = lq_pop | hq_pop;
  assign iss_src = ~lq_elig;
  assign iss_cmd = lq_elig ? lq_sel : hq_sel;

  dma_tq_engine #(.NSLOT(NSLOT), .LAT_W(LAT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .lat_i(lat_base), .go_i(iss_go), .go_src_i(iss_src),
    .go_tag_i(iss_cmd.tag), .go_size_i(iss_cmd.size), .free_o(eng_free),
    .cpl_o(cpl_valid), .cpl_src_o(cpl_src), .cpl_tag_o(cpl_tag));

  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    logic [IFL_W-1:0] lq_n, hq_n;
    logic l_inc, l_dec, h_inc, h_dec;
    assign l_inc = iss_go & ~iss_src & (iss_cmd.tag == TAG_W'(t));
    assign h_inc = iss_go &  iss_src & (iss_cmd.tag == TAG_W'(t));
    assign l_dec = cpl_valid & ~cpl_src & (cpl_tag == TAG_W'(t));
    assign h_dec = cpl_valid &  cpl_src & (cpl_tag == TAG_W'(t));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lq_n <= '0;
        hq_n <= '0;
      end else begin
        lq_n <= lq_n + IFL_W'(l_inc) - IFL_W'(l_dec);
        hq_n <= hq_n + IFL_W'(h_inc) - IFL_W'(h_dec);
      end
    end
    assign lq_busy[t]    = lq_n != '0;
    assign hq_busy[t]    = hq_n != '0;
    assign tag_status[t] = ~(lq_tags[t] | hq_tags[t] | lq_busy[t] | hq_busy[t]);
  end

  assign tag_idle_all = &(tag_status | ~tag_mask);

  assign xfer_start = iss_go;
  assign xfer_src   = iss_src;
  assign xfer_put   = iss_cmd.put;
  assign xfer_tag   = iss_cmd.tag;
  assign xfer_size  = iss_cmd.size;
  assign xfer_laddr = iss_cmd.laddr;
  assign xfer_eaddr = iss_cmd.eaddr;

  // named events for the bound checker
  assign iss_order    = iss_cmd.fence | iss_cmd.barrier;
  assign iss_tag_busy = iss_src ? hq_busy[iss_cmd.tag] : lq_busy[iss_cmd.tag];
endmodule

// File: rtl/dma_tq_checker.sv
module dma_tq_checker
  import dma_tq_pkg::*;
#(
  parameter int LQ_DEPTH = 16,
  parameter int HQ_DEPTH = 8,
  localparam int LQ_CW = $clog2(LQ_DEPTH + 1),
  localparam int HQ_CW = $clog2(HQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LQ_CW-1:0] lq_count,
  input logic [HQ_CW-1:0] hq_count,
  input logic             lq_elig,
  input logic             lc_err,
  input logic             xfer_start,
  input logic             xfer_src,
  input logic [TAG_W-1:0] xfer_tag,
  input logic             iss_order,
  input logic             iss_tag_busy,
  input logic             cpl_valid,
  input logic [TAG_W-1:0] cpl_tag,
  input logic [NTAG-1:0]  tag_status
);
  a_r1_lq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lq_count <= LQ_CW'(LQ_DEPTH));
  a_r1_hq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hq_count <= HQ_CW'(HQ_DEPTH));
  a_r2_local_first: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && xfer_src) |-> !lq_elig);
  a_r3_reject_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    lc_err |=> lq_count <= $past(lq_count));
  a_r5_ordered_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && iss_order) |-> !iss_tag_busy);
  a_r8_issue_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !tag_status[$past(xfer_tag)]);
  a_r9_cpl_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !tag_status[cpl_tag]);
endmodule

bind dma_tagq_ctrl dma_tq_checker #(.LQ_DEPTH(LQ_DEPTH), .HQ_DEPTH(HQ_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .lq_count(lq_count), .hq_count(hq_count), .lq_elig(lq_elig),
  .lc_err(lc_err), .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_tag(xfer_tag),
  .iss_order(iss_order), .iss_tag_busy(iss_tag_busy), .cpl_valid(cpl_valid),
  .cpl_tag(cpl_tag), .tag_status(tag_status));

// File: tb/dma_tagq_ctrl_tb.sv
module dma_tagq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lc_valid = 0, lc_put = 0, lc_fence = 0, lc_barrier = 0;
  logic [4:0] lc_tag = 0;  logic [14:0] lc_size = 0;
  logic [17:0] lc_laddr = 0; logic [31:0] lc_eaddr = 0;
  logic hs_valid = 0, hs_put = 0, hs_fence = 0, hs_barrier = 0;
  logic [4:0] hs_tag = 0;  logic [14:0] hs_size = 0;
  logic [17:0] hs_laddr = 0; logic [31:0] hs_eaddr = 0;
  logic [7:0] lat_base = 0;
  logic [31:0] tag_mask = 0;
  logic lc_ready, lc_err, hs_ready, hs_err, xfer_start, xfer_src, xfer_put;
  logic [4:0] xfer_tag, cpl_tag; logic [14:0] xfer_size;
  logic [17:0] xfer_laddr; logic [31:0] xfer_eaddr;
  logic cpl_valid, cpl_src, tag_idle_all; logic [31:0] tag_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_tagq_ctrl dut_i (.*);

  int cyc = 0, ord = 0, n_chk = 0, n_fail = 0, last_cpl = 0, laddr_bad = 0;
  int issue_cyc [64]; int issue_ord [64]; bit issue_put [64]; bit issue_src [64];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (xfer_start) begin
      issue_cyc[xfer_eaddr[5:0]] = cyc;
      issue_ord[xfer_eaddr[5:0]] = ord;
      issue_put[xfer_eaddr[5:0]] = xfer_put;
      issue_src[xfer_eaddr[5:0]] = xfer_src;
      if (xfer_laddr[5:0] != xfer_eaddr[5:0]) laddr_bad++;
      ord++;
    end
    if (cpl_valid) last_cpl = cyc;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit legal(input int s);
    return (s == 1 || s == 2 || s == 4 || s == 8) || (s % 16 == 0 && s >= 16 && s <= 16384);
  endfunction

  task automatic do_reset();
    lc_valid = 0; hs_valid = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input bit host, input bit put, input bit fen, input bit bar,
                      input int tag, input int size, input int id);
    @(negedge clk);
    if (host) begin
      hs_put = put; hs_fence = fen; hs_barrier = bar; hs_tag = 5'(tag);
      hs_size = 15'(size); hs_laddr = 18'(id); hs_eaddr = 32'(id); hs_valid = 1;
      #1; while (!hs_ready) begin @(negedge clk); #1; end
    end else begin
      lc_put = put; lc_fence = fen; lc_barrier = bar; lc_tag = 5'(tag);
      lc_size = 15'(size); lc_laddr = 18'(id); lc_eaddr = 32'(id); lc_valid = 1;
      #1; while (!lc_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    lc_valid = 0; hs_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (tag_status != 32'hFFFF_FFFF) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n0, mx, mn;
    bit inorder;
    do_reset();
    // reset state (R1, R8)
    #1;
    chk(lc_ready == 1, "R1 reset lc_ready", lc_ready, 1);
    chk(hs_ready == 1, "R1 reset hs_ready", hs_ready, 1);
    chk(tag_status == 32'hFFFF_FFFF, "R8 reset status", tag_status, 32'hFFFF_FFFF);
    chk(tag_idle_all == 1 && xfer_start == 0 && cpl_valid == 0, "R8 reset idle", tag_idle_all, 1);

    // R3: illegal command ignored at the ports
    n0 = ord;
    @(negedge clk);
    lc_tag = 4; lc_size = 3; lc_eaddr = 60; lc_laddr = 60; lc_valid = 1;
    #1; chk(lc_err == 1, "R3 err on size 3", lc_err, 1);
    @(negedge clk); lc_valid = 0;
    #1; chk(tag_status[4] == 1, "R3 rejected not queued", tag_status[4], 1);
    repeat (3) @(negedge clk);
    chk(ord == n0, "R3 rejected not issued", ord - n0, 0);

    // R9: completion latency
    lat_base = 5; push(0, 0, 0, 0, 3, 48, 50); drain();
    chk(last_cpl - issue_cyc[50] == 8, "R9 lat5 size48", last_cpl - issue_cyc[50], 8);
    lat_base = 0; push(0, 1, 0, 0, 3, 1, 51); drain();
    chk(last_cpl - issue_cyc[51] == 1, "R9 lat0 size1", last_cpl - issue_cyc[51], 1);
    lat_base = 255; push(1, 0, 0, 0, 3, 16, 52); drain();
    chk(last_cpl - issue_cyc[52] == 256, "R9 lat255 size16", last_cpl - issue_cyc[52], 256);
    lat_base = 0;

    // R1, R2, R10: fill engine, fill local queue, add host commands
    do_reset();
    for (int i = 0; i < 4; i++) push(0, 0, 0, 0, 1, 16384, i);
    for (int i = 4; i < 20; i++) push(0, 0, 0, 0, 2, 16, i);
    #1; chk(lc_ready == 0, "R1 local full ready low", lc_ready, 0);
    for (int i = 20; i < 23; i++) push(1, 0, 0, 0, 10, 16, i);
    #1; chk(hs_ready == 1, "R1 host 3 of 8 ready", hs_ready, 1);
    drain();
    mx = 0; mn = 1 << 30; inorder = 1;
    for (int i = 4; i < 20; i++) begin
      if (issue_ord[i] > mx) mx = issue_ord[i];
      if (i > 4 && issue_ord[i] != issue_ord[i-1] + 1) inorder = 0;
    end
    for (int i = 20; i < 23; i++) if (issue_ord[i] < mn) mn = issue_ord[i];
    chk(mx < mn, "R2 local before host", mx, mn);
    chk(issue_src[20] == 1 && issue_src[5] == 0, "R2 source field", issue_src[20], 1);
    chk(inorder, "R10 arrival order", inorder, 1);
    chk(laddr_bad == 0, "R4 addresses echoed", laddr_bad, 0);

    // R5, R7, R4, R8: fence
    do_reset();
    push(0, 0, 0, 0, 5, 16384, 30);
    push(0, 0, 1, 0, 5, 16, 31);
    push(0, 1, 0, 0, 5, 16, 32);
    push(0, 0, 0, 0, 9, 16, 33);
    tag_mask = 32'h0000_0020; #1;
    chk(tag_idle_all == 0, "R8 masked busy tag", tag_idle_all, 0);
    tag_mask = 32'h0010_0000; #1;
    chk(tag_idle_all == 1, "R8 masked idle tag", tag_idle_all, 1);
    chk(tag_status[5] == 0, "R8 status busy bit", tag_status[5], 0);
    drain();
    chk(issue_cyc[31] - issue_cyc[30] >= 1024, "R5 fence waits", issue_cyc[31] - issue_cyc[30], 1024);
    chk(issue_ord[32] < issue_ord[31], "R5 later plain passes fence", issue_ord[32], issue_ord[31]);
    chk(issue_ord[33] < issue_ord[31], "R7 other tag not blocked", issue_ord[33], issue_ord[31]);
    chk(issue_put[32] == 1 && issue_put[31] == 0, "R4 direction", issue_put[32], 1);
    tag_mask = 32'hFFFF_FFFF; #1;
    chk(tag_status == 32'hFFFF_FFFF && tag_idle_all, "R8 idle after drain", tag_status, 32'hFFFF_FFFF);

    // R6, R7: barrier
    do_reset();
    push(0, 0, 0, 0, 7, 16384, 40);
    push(0, 0, 0, 1, 7, 16, 41);
    push(0, 0, 0, 0, 7, 16, 42);
    push(0, 0, 0, 0, 8, 16, 43);
    drain();
    chk(issue_cyc[41] - issue_cyc[40] >= 1024, "R6 barrier waits", issue_cyc[41] - issue_cyc[40], 1024);
    chk(issue_ord[42] > issue_ord[41], "R6 later held behind barrier", issue_ord[42], issue_ord[41]);
    chk(issue_ord[43] < issue_ord[41], "R7 other tag passes barrier", issue_ord[43], issue_ord[41]);

    // R3: sweep every size on the host port
    do_reset();
    for (int s = 0; s < 32768; s++) begin
      @(negedge clk);
      hs_size = 15'(s); hs_tag = 0; hs_eaddr = 63; hs_laddr = 63; hs_valid = 1;
      #1; chk(hs_err == !legal(s), "R3 size sweep", hs_err, !legal(s));
    end
    hs_valid = 0;
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule